// File: doc/BRIEF.md
# Memory Error Syndrome Capture Register

This block keeps a 64-bit syndrome word that describes correctable and fatal ECC errors reported by three RAM arrays: a cache tag array, a cache data array and a snoop filter array. Each array can report one error per cycle. An error comes with a strobe, a 4-bit bank/way code, a 14-bit row index and a flag that marks it as abort-causing. The ECC checkers and the RAMs sit outside the block.

The first error after a clear fixes the recorded location and sets a sticky Valid bit. Later errors are counted in one of two saturating 8-bit counters. An error goes to the repeat counter when it comes from the recorded array and bank/way, and to the other counter in every other case. The first abort-causing error sets a sticky Fatal bit and takes over the recorded location, even when Valid was already set. When software writes the register, whatever the data, the word becomes 0x10000000 and the events of that cycle are dropped. Reset clears the word to zero.

Top module: `mem_err_syndrome`

## Requirements
- R1: After reset `syndrome` reads 0.
- R2: Field positions in `syndrome`:
  - bit 63 is Fatal.
  - bits 47:40 are the other count.
  - bits 39:32 are the repeat count.
  - bit 31 is Valid.
  - bits 30:24 are the array code.
  - bits 21:18 are the bank/way code.
  - bits 16:3 are the index.
  - bits 62:48, 23:22, 17 and 2:0 are always 0.
- R3: While Valid is 0, an error sets Valid and records the array code, bank/way and index. Both counts are cleared. The array codes are 0x10 for tag (source 0), 0x11 for data (source 1) and 0x12 for snoop filter (source 2).
- R4: While Valid is 1, an error whose array code and bank/way equal the recorded ones increments the repeat count. The index takes no part in the match.
- R5: While Valid is 1, an error that does not match the recorded array code and bank/way increments the other count.
- R6: The first error that carries the fatal flag sets Fatal and overwrites the recorded location. Valid and Fatal then stay set until a write.
- R7: A write loads 0x10000000 on the next cycle. Error events in the same cycle as the write are discarded.
- R8: When several errors arrive in the same cycle while Valid is 0, exactly one is captured and the other count becomes 1. A fatal error is chosen over a non-fatal one. Among errors of equal standing the order is tag, then data, then snoop filter.
- R9: While Valid is 1, several non-matching errors in one cycle add exactly 1 to the other count.
- R10: Both counts saturate at 255 and do not wrap.
- R11: Once Fatal is set, a later fatal error is counted like any other error and leaves the recorded location unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_vld | input | 3 | Per-source error strobe (bit 0 tag, 1 data, 2 snoop filter) |
| err_fatal | input | 3 | Per-source abort-causing flag |
| err_way | input | 3x4 | Per-source bank/way code |
| err_idx | input | 3x14 | Per-source row index |
| sw_wr | input | 1 | Software write strobe (the data written is ignored) |
| syndrome | output | 64 | Syndrome word |

## Verification
Two of the block's functions can fall in the same cycle. A software write can coincide with error events, and the capture of a new location can coincide with counting.

The bench provokes both cases on purpose:
- It asserts the write strobe together with a fatal error and checks that the next word is exactly the write value.
- It presents errors from several arrays at once, both before and after Valid is set, including a fatal error mixed with non-fatal ones.

It judges each case against a bench model that classifies every event against the location recorded before that cycle.

// File: rtl/mes_pkg.sv
package mes_pkg;
  localparam int NSRC      = 3;
  localparam int WAY_W     = 4;
  localparam int IDX_W     = 14;
  localparam int RAMID_W   = 7;
  localparam int CNT_W     = 8;
  localparam int SRC_W     = $clog2(NSRC);
  localparam logic [RAMID_W-1:0] RAMID_BASE = 7'h10;
  localparam logic [63:0] WR_VALUE = 64'h0000_0000_1000_0000;

  function automatic logic [RAMID_W-1:0] ramid_of(input int unsigned src);
    return RAMID_BASE + RAMID_W'(src);
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c, input logic inc);
    if (inc && (c != {CNT_W{1'b1}})) return c + 1'b1;
    return c;
  endfunction

  function automatic logic [63:0] pack_word(input logic fatal, input logic [CNT_W-1:0] oth,
                                            input logic [CNT_W-1:0] rep, input logic valid,
                                            input logic [RAMID_W-1:0] ram,
                                            input logic [WAY_W-1:0] way,
                                            input logic [IDX_W-1:0] idx);
    return {fatal, 15'b0, oth, rep, valid, ram, 2'b0, way, 1'b0, idx, 3'b0};
  endfunction
endpackage

// File: rtl/mes_arbiter.sv
module mes_arbiter
  import mes_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int WW = WAY_W,
  parameter int IW = IDX_W,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0]         fatal,
  input  logic [N-1:0][WW-1:0] way,
  input  logic [N-1:0][IW-1:0] idx,
  output logic                 any_vld,
  output logic                 any_fatal,
  output logic                 multi,
  output logic [N-1:0]         sel_oh,
  output logic [SW-1:0]        sel_src,
  output logic                 sel_fatal,
  output logic [WW-1:0]        sel_way,
  output logic [IW-1:0]        sel_idx
);
  logic [N-1:0] fat_v;
  logic [N-1:0] cand;

  assign fat_v     = vld & fatal;
  assign any_vld   = |vld;
  assign any_fatal = |fat_v;
  assign multi     = ($countones(vld) > 1);
  assign cand      = any_fatal ? fat_v : vld;

  always_comb begin
    sel_oh  = '0;
    sel_src = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        sel_oh  = '0;
        sel_oh[i] = 1'b1;
        sel_src = SW'(i);
      end
    end
  end

  assign sel_fatal = any_fatal;
  assign sel_way   = way[sel_src];
  assign sel_idx   = idx[sel_src];

  always_comb begin
    if (!$isunknown(vld) && !$isunknown(fatal)) begin
      AST_SEL_ONEHOT: assert ($onehot0(sel_oh) && (any_vld == (sel_oh != '0))); // R8
      AST_FATAL_FIRST: assert (!any_fatal || ((sel_oh & fat_v) != '0)); // R8
    end
  end
endmodule

// File: rtl/mes_classify.sv
module mes_classify
  import mes_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int WW = WAY_W
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0][WW-1:0] way,
  input  logic [RAMID_W-1:0]   rec_ram,
  input  logic [WW-1:0]        rec_way,
  output logic                 hit_any,
  output logic                 miss_any
);
  logic [N-1:0] hit;
  logic [N-1:0] miss;

  for (genvar s = 0; s < N; s++) begin : g_src
    logic same;
    assign same    = (ramid_of(s) == rec_ram) && (way[s] == rec_way);
    assign hit[s]  = vld[s] && same;
    assign miss[s] = vld[s] && !same;
  end

  assign hit_any  = |hit;
  assign miss_any = |miss;

  always_comb begin
    if (!$isunknown(vld)) begin
      AST_HIT_SINGLE: assert ($onehot0(hit)); // R4
    end
  end
endmodule

// File: rtl/mes_sat_cnt.sv
module mes_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (inc && cnt != MAXV)  cnt <= cnt + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == MAXV) |=> (cnt == MAXV)); // R10
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1))); // R9
endmodule

// File: rtl/mem_err_syndrome.sv
module mem_err_syndrome
  import mes_pkg::*;
#(
  parameter int N_SRC = NSRC
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SRC-1:0]              err_vld,
  input  logic [N_SRC-1:0]              err_fatal,
  input  logic [N_SRC-1:0][WAY_W-1:0]   err_way,
  input  logic [N_SRC-1:0][IDX_W-1:0]   err_idx,
  input  logic                          sw_wr,
  output logic [63:0]                   syndrome
);
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic               fatal_q, valid_q;
  logic [RAMID_W-1:0] ram_q;
  logic [WAY_W-1:0]   way_q;
  logic [IDX_W-1:0]   idx_q;
  logic [CNT_W-1:0]   rep_cnt, oth_cnt;

  logic               any_vld, any_fatal, multi, sel_fatal;
  logic [N_SRC-1:0]   sel_oh;
  logic [SW-1:0]      sel_src;
  logic [WAY_W-1:0]   sel_way;
  logic [IDX_W-1:0]   sel_idx;
  logic               hit_any, miss_any;

  logic               first_cap, fatal_cap, loc_upd, rep_inc, oth_inc, cnt_load;
  logic [CNT_W-1:0]   oth_load_val;

  mes_arbiter #(.N(N_SRC), .WW(WAY_W), .IW(IDX_W)) u_arb (
    .vld(err_vld), .fatal(err_fatal), .way(err_way), .idx(err_idx),
    .any_vld(any_vld), .any_fatal(any_fatal), .multi(multi),
    .sel_oh(sel_oh), .sel_src(sel_src), .sel_fatal(sel_fatal),
    .sel_way(sel_way), .sel_idx(sel_idx)
  );

  mes_classify #(.N(N_SRC), .WW(WAY_W)) u_cls (
    .vld(err_vld), .way(err_way), .rec_ram(ram_q), .rec_way(way_q),
    .hit_any(hit_any), .miss_any(miss_any)
  );

  // named internal events
  assign first_cap    = !sw_wr && !valid_q && any_vld;
  assign fatal_cap    = !sw_wr && valid_q && !fatal_q && any_fatal;
  assign loc_upd      = first_cap || fatal_cap;
  assign rep_inc      = !sw_wr && valid_q && hit_any;
  assign oth_inc      = !sw_wr && valid_q && miss_any;
  assign cnt_load     = sw_wr || first_cap;
  assign oth_load_val = (first_cap && multi) ? CNT_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fatal_q <= 1'b0;
      valid_q <= 1'b0;
      ram_q   <= '0;
      way_q   <= '0;
      idx_q   <= '0;
    end else if (sw_wr) begin
      fatal_q <= WR_VALUE[63];
      valid_q <= WR_VALUE[31];
      ram_q   <= WR_VALUE[30:24];
      way_q   <= WR_VALUE[21:18];
      idx_q   <= WR_VALUE[16:3];
    end else begin
      if (first_cap) valid_q <= 1'b1;
      if (loc_upd) begin
        ram_q <= ramid_of(32'(sel_src));
        way_q <= sel_way;
        idx_q <= sel_idx;
        if (sel_fatal) fatal_q <= 1'b1;
      end
    end
  end

  mes_sat_cnt #(.W(CNT_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val('0),
    .inc(rep_inc), .cnt(rep_cnt)
  );

  mes_sat_cnt #(.W(CNT_W)) u_oth (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(oth_load_val),
    .inc(oth_inc), .cnt(oth_cnt)
  );

  assign syndrome = pack_word(fatal_q, oth_cnt, rep_cnt, valid_q, ram_q, way_q, idx_q);

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !sw_wr) |=> valid_q); // R6
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_q && !sw_wr) |=> fatal_q); // R6
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (syndrome == WR_VALUE)); // R7
  AST_FIRST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    first_cap |=> (valid_q && rep_cnt == '0)); // R3
  AST_FATAL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_q && !sw_wr) |=> ($stable(ram_q) && $stable(way_q) && $stable(idx_q))); // R11
endmodule

// File: tb/mem_err_syndrome_bench.sv
module mem_err_syndrome_bench;
  import mes_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] err_vld = '0;
  logic [2:0] err_fatal = '0;
  logic [2:0][3:0] err_way = '0;
  logic [2:0][13:0] err_idx = '0;
  logic sw_wr = 1'b0;
  logic [63:0] syndrome;

  mem_err_syndrome u_mem_err_syndrome (
    .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_fatal(err_fatal),
    .err_way(err_way), .err_idx(err_idx), .sw_wr(sw_wr), .syndrome(syndrome)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { logic [63:0] exp; string tag; } item_t;
  item_t q[$];

  // bench model state
  bit m_fat, m_val;
  int m_ram, m_way, m_idx, m_rep, m_oth;

  function automatic logic [63:0] m_word();
    logic [63:0] w = '0;
    w[63] = m_fat; w[47:40] = 8'(m_oth); w[39:32] = 8'(m_rep); w[31] = m_val;
    w[30:24] = 7'(m_ram); w[21:18] = 4'(m_way); w[16:3] = 14'(m_idx);
    return w;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] v, input logic [2:0] f,
                       input logic [11:0] w, input logic [41:0] ix, input bit wr);
    int cnt = 0, pick = -1, fpick = -1;
    bit hit = 0, miss = 0;
    if (wr) begin
      m_fat = 0; m_val = 0; m_ram = 'h10; m_way = 0; m_idx = 0; m_rep = 0; m_oth = 0;
      return;
    end
    for (int s = 0; s < 3; s++) if (v[s]) begin
      cnt++;
      if (pick < 0) pick = s;
      if (f[s] && fpick < 0) fpick = s;
      if ((s + 'h10) == m_ram && int'(w[s*4 +: 4]) == m_way) hit = 1; else miss = 1;
    end
    if (fpick >= 0) pick = fpick;
    if (!m_val) begin
      if (cnt > 0) begin
        m_val = 1; m_fat = (fpick >= 0);
        m_ram = pick + 'h10; m_way = int'(w[pick*4 +: 4]); m_idx = int'(ix[pick*14 +: 14]);
        m_rep = 0; m_oth = (cnt > 1) ? 1 : 0;
      end
    end else begin
      if (hit && m_rep < 255) m_rep++;
      if (miss && m_oth < 255) m_oth++;
      if (!m_fat && fpick >= 0) begin
        m_fat = 1;
        m_ram = fpick + 'h10; m_way = int'(w[fpick*4 +: 4]); m_idx = int'(ix[fpick*14 +: 14]);
      end
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input logic [2:0] v, input logic [2:0] f, input logic [11:0] w,
                      input logic [41:0] ix, input bit wr, input string tag);
    item_t it;
    @(negedge clk);
    err_vld = v; err_fatal = f; err_way = w; err_idx = ix; sw_wr = wr;
    model(v, f, w, ix, wr);
    it.exp = m_word(); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    err_vld = '0; err_fatal = '0; sw_wr = 1'b0;
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        #(CLK_PERIOD/4);
        chk(syndrome, it.exp, it.tag);
      end
    end
  end

  function automatic logic [11:0] ways(input int a, input int b, input int c);
    return {4'(c), 4'(b), 4'(a)};
  endfunction
  function automatic logic [41:0] idxs(input int a, input int b, input int c);
    return {14'(c), 14'(b), 14'(a)};
  endfunction

  initial begin
    m_fat = 0; m_val = 0; m_ram = 0; m_way = 0; m_idx = 0; m_rep = 0; m_oth = 0;
    repeat (3) @(negedge clk);
    chk(syndrome, 64'h0, "R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    chk(syndrome, 64'h0, "R1 after reset release");

    step(3'b001, 3'b000, ways(3,0,0), idxs('h123,0,0), 0, "R3 first tag capture");
    step(3'b001, 3'b000, ways(3,0,0), idxs('h3FFF,0,0), 0, "R4 repeat, index ignored");
    step(3'b010, 3'b000, ways(0,3,0), idxs(0,5,0), 0, "R5 other from data array");
    step(3'b001, 3'b000, ways(4,0,0), idxs('h123,0,0), 0, "R5 other from tag way 4");
    step(3'b100, 3'b100, ways(0,0,9), idxs(0,0,'h2AB), 0, "R6 fatal overwrites location");
    idle();
    chk(syndrome[63] & syndrome[31], 1'b1, "R6 sticky Valid and Fatal");
    step(3'b010, 3'b010, ways(0,2,0), idxs(0,7,0), 0, "R11 second fatal only counted");
    step(3'b111, 3'b111, ways(1,1,1), idxs(1,1,1), 1, "R7 write beats same-cycle events");
    step(3'b000, 3'b000, ways(0,0,0), idxs(0,0,0), 0, "R7 write value held");
    step(3'b111, 3'b000, ways(6,2,5), idxs(11,22,33), 0, "R8 tag wins, other=1");
    step(3'b000, 3'b000, 0, 0, 1, "R7 clear");
    step(3'b110, 3'b100, ways(0,1,14), idxs(0,44,55), 0, "R8 fatal snoop chosen over data");
    step(3'b111, 3'b000, ways(8,7,14), idxs(1,2,3), 0, "R9 multi miss plus hit");
    step(3'b011, 3'b000, ways(8,7,0), idxs(1,2,3), 0, "R9 two misses add one");
    for (int k = 0; k < 260; k++)
      step(3'b100, 3'b000, ways(0,0,14), idxs(0,0,k), 0, "R10 repeat saturation");
    idle();
    idle();
    chk(syndrome[39:32], 8'd255, "R10 repeat stays at 255");
    chk(syndrome & 64'h7FFF_0000_00C2_0007, 64'h0, "R2 reserved bits zero");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule